// File: doc/BRIEF.md
# Two-Point Calibrated ADC Code to Millivolt Converter

This block takes one raw 12-bit converter sample at a time, tagged with a channel number and a packed 32-bit divider ratio, and returns a voltage in millivolts. The sample is first mapped through one of two straight lines. Each line is defined by two (voltage, code) points: a large-range line through 4200 mV and 3600 mV, and a small-range line through 1000 mV and 100 mV. A line result below zero becomes zero. Two channels return the line result as it is. Every other channel is scaled back through its external resistor divider, with the division rounded to the nearest integer.

The code value of each calibration point is rebuilt from a per-part trim byte. The trims are loaded with a one-cycle strobe. Both divisions in a conversion share a single restoring divider that produces one quotient bit per cycle. The input side therefore accepts a new sample only after the previous result has left through the output handshake.

Top module: `adc_volt_conv`

## Requirements
- R1: On a `cal_load` pulse, each calibrated point code becomes (trim byte + nominal code − 128) × 4. The nominal codes are 856 and 733 for the large line and 833 and 80 for the small line. Trim bits 7:0 calibrate the first point (4200 mV or 1000 mV) and trim bits 15:8 calibrate the second point (3600 mV or 100 mV).
- R2: The line value is (V0 − V1) × (raw − A1) / (A0 − A1) + V1, computed in signed arithmetic, with the quotient truncated toward zero.
- R3: A negative line value is output as 0.
- R4: Channel 5 uses the large line and channel 1 uses the small line. Both output the line value with no ratio correction.
- R5: Every other channel takes the small-line value L and outputs (L × D + N/2) / N, using integer division. N is `in_ratio[31:16]` and D is `in_ratio[15:0]`.
- R6: When N is 0, the ratio correction is skipped and the small-line value is output unchanged.
- R7: When the selected line's two calibrated codes are equal, the output is 0 with `out_err` = 1. Otherwise `out_err` = 0.
- R8: `in_ready` is low from the cycle after a sample is accepted until its result has been taken. While `out_valid` is high and `out_ready` is low, `out_mv` and `out_err` do not change.
- R9: When `cal_load` and an input handshake happen in the same cycle, the accepted sample is converted with the calibration in force before that cycle. Later samples use the new trims.
- R10: After reset, `in_ready` = 1 and `out_valid` = 0, and every point code equals nominal code × 4, which is the value a trim byte of 0x80 gives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_load | input | 1 | Strobe that loads both trim words |
| big_trim | input | 16 | Trim bytes for the large line |
| sml_trim | input | 16 | Trim bytes for the small line |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Converter idle and able to take a sample |
| in_chan | input | 5 | Channel number |
| in_raw | input | 12 | Raw converter code |
| in_ratio | input | 32 | Divider ratio: numerator in bits 31:16, denominator in bits 15:0 |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_mv | output | 48 | Voltage in millivolts |
| out_err | output | 1 | Degenerate calibration: the two point codes are equal |

## Verification
A trim load and a sample handshake can land in the same clock edge. The conversion must then use the old points while the new points are stored for the next sample. The bench forces this by raising `cal_load` with new trims in the very cycle `in_valid` meets `in_ready`. It compares that result against a model that still holds the previous trims, and it checks the following sample against the new trims. Random backpressure on `out_ready` also overlaps a held result with a pending sample, and the bench judges that overlap by the output's stability and by `in_ready` staying low.

// File: rtl/adc_volt_conv.sv
module adc_volt_conv #(
  parameter int CODE_W = 12,
  parameter int CH_W   = 5,
  parameter int TRIM_W = 8,
  parameter int DIV_W  = 48,
  parameter int BIG_V0 = 4200,
  parameter int BIG_V1 = 3600,
  parameter int SML_V0 = 1000,
  parameter int SML_V1 = 100,
  parameter int BIG_N0 = 856,
  parameter int BIG_N1 = 733,
  parameter int SML_N0 = 833,
  parameter int SML_N1 = 80,
  parameter int BIG_CH = 5,
  parameter int SML_CH = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cal_load,
  input  logic [2*TRIM_W-1:0]   big_trim,
  input  logic [2*TRIM_W-1:0]   sml_trim,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [CH_W-1:0]       in_chan,
  input  logic [CODE_W-1:0]     in_raw,
  input  logic [31:0]           in_ratio,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [DIV_W-1:0]      out_mv,
  output logic                  out_err
);
  localparam int PT_W  = CODE_W + 4;
  localparam int DSR_W = PT_W + 1;
  localparam int CNT_W = $clog2(DIV_W + 1);
  localparam logic signed [DIV_W-1:0] BIG_VD = DIV_W'(BIG_V0 - BIG_V1);
  localparam logic signed [DIV_W-1:0] SML_VD = DIV_W'(SML_V0 - SML_V1);

  function automatic logic signed [PT_W-1:0] cal_pt(input logic [TRIM_W-1:0] t, input int nom);
    int tmp;
    tmp = (int'(t) + nom - (1 << (TRIM_W - 1))) * 4;
    return PT_W'(tmp);
  endfunction

  typedef enum logic [1:0] {S_IDLE, S_LDIV, S_RDIV, S_DONE} st_t;
  st_t state;

  logic signed [PT_W-1:0] big_a0, big_a1, sml_a0, sml_a1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      big_a0 <= cal_pt(TRIM_W'(1 << (TRIM_W - 1)), BIG_N0);
      big_a1 <= cal_pt(TRIM_W'(1 << (TRIM_W - 1)), BIG_N1);
      sml_a0 <= cal_pt(TRIM_W'(1 << (TRIM_W - 1)), SML_N0);
      sml_a1 <= cal_pt(TRIM_W'(1 << (TRIM_W - 1)), SML_N1);
    end else if (cal_load) begin
      big_a0 <= cal_pt(big_trim[TRIM_W-1:0], BIG_N0);
      big_a1 <= cal_pt(big_trim[2*TRIM_W-1:TRIM_W], BIG_N1);
      sml_a0 <= cal_pt(sml_trim[TRIM_W-1:0], SML_N0);
      sml_a1 <= cal_pt(sml_trim[2*TRIM_W-1:TRIM_W], SML_N1);
    end
  end

  // accept-side line setup
  logic                    sel_big, direct;
  logic signed [PT_W-1:0]  a0, a1;
  logic signed [PT_W:0]    den_s, den_mag;
  logic signed [DIV_W-1:0] vd, v1, raw_s, prod_s, prod_abs;

  assign sel_big  = in_chan == CH_W'(BIG_CH);
  assign direct   = sel_big || (in_chan == CH_W'(SML_CH));
  assign a0       = sel_big ? big_a0 : sml_a0;
  assign a1       = sel_big ? big_a1 : sml_a1;
  assign vd       = sel_big ? BIG_VD : SML_VD;
  assign v1       = sel_big ? DIV_W'(BIG_V1) : DIV_W'(SML_V1);
  assign den_s    = a0 - a1;
  assign den_mag  = den_s[PT_W] ? -den_s : den_s;
  assign raw_s    = $signed({{(DIV_W-CODE_W){1'b0}}, in_raw});
  assign prod_s   = vd * (raw_s - a1);
  assign prod_abs = prod_s[DIV_W-1] ? -prod_s : prod_s;

  // shared restoring divider
  logic [DIV_W-1:0]  dvd;
  logic [DSR_W-1:0]  rem, dsr;
  logic [CNT_W-1:0]  cnt;
  logic [DSR_W:0]    trial;
  logic              ge, div_last;
  logic [DSR_W-1:0]  rem_nx;
  logic [DIV_W-1:0]  q_nx;

  assign trial    = {rem, dvd[DIV_W-1]};
  assign ge       = trial >= {1'b0, dsr};
  assign rem_nx   = ge ? DSR_W'(trial - {1'b0, dsr}) : trial[DSR_W-1:0];
  assign q_nx     = {dvd[DIV_W-2:0], ge};
  assign div_last = cnt == CNT_W'(DIV_W - 1);

  // line finish and ratio setup
  logic                    neg, direct_r, err;
  logic signed [DIV_W-1:0] v1_r, lq_s, line_s;
  logic [DIV_W-1:0]        volt, scaled, res;
  logic [31:0]             ratio_r;
  logic [15:0]             rnum, rden;

  assign lq_s   = neg ? -$signed(q_nx) : $signed(q_nx);
  assign line_s = lq_s + v1_r;
  assign volt   = line_s[DIV_W-1] ? '0 : line_s;
  assign rnum   = ratio_r[31:16];
  assign rden   = ratio_r[15:0];
  assign scaled = volt * DIV_W'(rden) + DIV_W'(rnum >> 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      dvd      <= '0;
      rem      <= '0;
      dsr      <= '0;
      cnt      <= '0;
      neg      <= 1'b0;
      direct_r <= 1'b0;
      v1_r     <= '0;
      ratio_r  <= '0;
      res      <= '0;
      err      <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (in_valid) begin
          if (den_s == '0) begin
            res   <= '0;
            err   <= 1'b1;
            state <= S_DONE;
          end else begin
            dvd      <= prod_abs;
            rem      <= '0;
            dsr      <= den_mag;
            cnt      <= '0;
            neg      <= prod_s[DIV_W-1] ^ den_s[PT_W];
            v1_r     <= v1;
            direct_r <= direct;
            ratio_r  <= in_ratio;
            err      <= 1'b0;
            state    <= S_LDIV;
          end
        end
        S_LDIV: begin
          dvd <= q_nx;
          rem <= rem_nx;
          cnt <= cnt + 1'b1;
          if (div_last) begin
            if (direct_r || rnum == '0) begin
              res   <= volt;
              state <= S_DONE;
            end else begin
              dvd   <= scaled;
              rem   <= '0;
              dsr   <= DSR_W'(rnum);
              cnt   <= '0;
              state <= S_RDIV;
            end
          end
        end
        S_RDIV: begin
          dvd <= q_nx;
          rem <= rem_nx;
          cnt <= cnt + 1'b1;
          if (div_last) begin
            res   <= q_nx;
            state <= S_DONE;
          end
        end
        default: if (out_ready) state <= S_IDLE;
      endcase
    end
  end

  assign in_ready  = state == S_IDLE;
  assign out_valid = state == S_DONE;
  assign out_mv    = res;
  assign out_err   = err;

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_mv) && $stable(out_err));
  assert_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);
  assert_err_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> out_mv == '0);
  assert_flat_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && den_s == '0 |=> out_valid && out_err);
  assert_rem_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LDIV || state == S_RDIV) |-> rem < dsr);
endmodule

// File: tb/adc_volt_conv_bench.sv
module adc_volt_conv_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cal_load = 1'b0;
  logic [15:0] big_trim = '0, sml_trim = '0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [4:0] in_chan = '0;
  logic [11:0] in_raw = '0;
  logic [31:0] in_ratio = '0;
  logic in_ready, out_valid, out_err;
  logic [47:0] out_mv;

  int n_checks = 0, n_fail = 0;
  logic [15:0] m_bt = 16'h8080, m_st = 16'h8080;

  always #5 clk = ~clk;

  adc_volt_conv u_adc_volt_conv (
    .clk(clk), .rst_n(rst_n), .cal_load(cal_load), .big_trim(big_trim), .sml_trim(sml_trim),
    .in_valid(in_valid), .in_ready(in_ready), .in_chan(in_chan), .in_raw(in_raw),
    .in_ratio(in_ratio), .out_valid(out_valid), .out_ready(out_ready), .out_mv(out_mv),
    .out_err(out_err));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint cpt(input logic [7:0] t, input longint nom);
    return (longint'(t) + nom - 128) * 4;
  endfunction

  function automatic longint model(input int ch, input int raw, input logic [31:0] ratio,
                                   input logic [15:0] bt, input logic [15:0] st, output bit e);
    longint a0, a1, v0, v1, den, q, line, n, d;
    e = 0;
    if (ch == 5) begin a0 = cpt(bt[7:0], 856); a1 = cpt(bt[15:8], 733); v0 = 4200; v1 = 3600; end
    else         begin a0 = cpt(st[7:0], 833); a1 = cpt(st[15:8], 80);  v0 = 1000; v1 = 100;  end
    den = a0 - a1;
    if (den == 0) begin e = 1; return 0; end
    q = ((v0 - v1) * (longint'(raw) - a1)) / den;
    line = q + v1;
    if (line < 0) line = 0;
    if (ch == 5 || ch == 1) return line;
    n = longint'(ratio[31:16]);
    d = longint'(ratio[15:0]);
    if (n == 0) return line;
    return (line * d + n / 2) / n;
  endfunction

  task automatic load_cal(input logic [15:0] bt, input logic [15:0] st);
    @(negedge clk);
    cal_load = 1'b1; big_trim = bt; sml_trim = st;
    @(posedge clk); #1;
    cal_load = 1'b0;
    m_bt = bt; m_st = st;
  endtask

  task automatic run(input int ch, input int raw, input logic [31:0] ratio, input string req,
                     input bit calnow = 0, input logic [15:0] nbt = '0, input logic [15:0] nst = '0);
    longint exp;
    bit e, seen, prev_rdy;
    logic [47:0] held;
    logic held_err;
    exp = model(ch, raw, ratio, m_bt, m_st, e);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_chan = 5'(ch); in_raw = 12'(raw); in_ratio = ratio;
    if (calnow) begin cal_load = 1'b1; big_trim = nbt; sml_trim = nst; end
    @(posedge clk); #1;
    in_valid = 1'b0; cal_load = 1'b0;
    if (calnow) begin m_bt = nbt; m_st = nst; end
    chk(in_ready == 1'b0, "R8", longint'(in_ready), 0);
    seen = 0; prev_rdy = 1;
    held = '0; held_err = 1'b0;
    forever begin
      @(negedge clk);
      if (out_valid) begin
        if (!seen) begin
          chk(longint'(out_mv) == exp, req, longint'(out_mv), exp);
          chk(out_err == e, "R7", longint'(out_err), longint'(e));
          seen = 1;
        end else if (!prev_rdy) begin
          chk(out_mv == held && out_err == held_err && in_ready == 1'b0, "R8",
              longint'(out_mv), longint'(held));
        end
        held = out_mv; held_err = out_err;
        prev_rdy = ($urandom_range(0, 2) != 0);
        out_ready = prev_rdy;
        if (prev_rdy) break;
      end
    end
    @(posedge clk); #1;
    out_ready = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R10", longint'({in_ready, out_valid}), 2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R10", longint'({in_ready, out_valid}), 2);
    run(5, 3424, 32'h0, "R10");
    run(1, 2000, 32'h0, "R4");
    run(5, 100, 32'h0, "R4");
    run(1, 1234, 32'h0, "R2");
    run(14, 2500, {16'd68, 16'd900}, "R5");
    run(7, 1001, {16'd2, 16'd1}, "R5");
    run(9, 2222, {16'd0, 16'd1234}, "R6");
    load_cal(16'h8080, 16'hFF80);
    run(1, 0, 32'h0, "R3");
    run(20, 5, {16'd3, 16'd8}, "R3");
    load_cal(16'h7B00, 16'h8080);
    run(5, 3000, 32'h0, "R7");
    run(7, 3000, {16'd100, 16'd125}, "R7");
    load_cal(16'h8080, 16'h8080);
    run(1, 1500, 32'h0, "R9", 1, 16'h20F0, 16'h10E0);
    run(1, 1500, 32'h0, "R1");
    run(5, 2000, 32'h0, "R1");
    for (int i = 0; i < 300; i++) begin
      int sel, ch;
      if ($urandom_range(0, 9) == 0)
        load_cal(16'($urandom), 16'($urandom));
      sel = $urandom_range(0, 3);
      ch = (sel == 0) ? 5 : (sel == 1) ? 1 : $urandom_range(0, 31);
      if (i % 50 == 7)
        run(ch, $urandom_range(0, 4095), $urandom, "R9", 1, 16'($urandom), 16'($urandom));
      else
        run(ch, $urandom_range(0, 4095), $urandom, (ch == 5 || ch == 1) ? "R4" : "R5");
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule